// File: doc/BRIEF.md
# Inverting Parity Bus Bridge with Registered Error Flag

This block joins an 8-bit A-side bus to a 9-bit B-side bus whose extra bit carries parity. Two active-low enables choose what it does. It can pass inverted A data toward B and generate a parity bit. It can pass inverted B data toward A and check the incoming nine bits. It can isolate both sides. It can also drive A data toward B with a deliberately wrong parity bit, which lets a system test its own error path. Every bus output is the complement of the bus input on the other side.

The parity check result is captured into a flag register on each rising clock edge. An active-low clear empties the register at any time. The error pin is modelled as an open-collector output: a level that is low on error plus a drive-enable that is high only while that level is low. Tri-state pins are modelled as separate input, output and output-enable signals.

Top module: `par_bridge`

## Requirements
- R1: With en_a_n=1 and en_b_n=0 (toward B), b_oe=1, par_oe=1, a_oe=0 and b_out is the bitwise complement of a_in.
- R2: Toward B, par_out makes the nine driven B-side bits (b_out plus par_out) contain an odd number of ones.
- R3: With en_a_n=0 and en_b_n=1 (toward A), a_oe=1, b_oe=0, par_oe=0 and a_out is the bitwise complement of b_in.
- R4: Toward A, the edge after the inputs settle captures an error (err_n=0) exactly when b_in together with par_in holds an even number of ones; otherwise err_n=1.
- R5: With both enables at 0 (diagnostic), b_oe=1, par_oe=1, a_oe=0, b_out is the complement of a_in, par_out is the opposite of the R2 value, and the next rising edge captures an error.
- R6: Toward B, the next rising edge captures no error (err_n=1).
- R7: With both enables at 1 (isolated), a_oe, b_oe and par_oe are all 0, and the next rising edge captures an error exactly when a_in holds an odd number of ones.
- R8: The flag changes only on a rising clk edge; input changes between edges leave err_n unchanged.
- R9: clr_n=0 forces err_n=1 at once, without waiting for a clock edge, and holds it there while clr_n stays 0, whatever clk does.
- R10: err_drv is 1 exactly when err_n is 0, so the error pin is driven only to signal an error.
- R11: After a clear, before any loading edge, err_n=1 and err_drv=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flag register clock, rising edge |
| clr_n | input | 1 | Asynchronous active-low flag clear |
| en_a_n | input | 1 | Active-low enable of the A-side drivers |
| en_b_n | input | 1 | Active-low enable of the B-side drivers |
| a_in | input | DATA_W | Value sensed on the A-side pins |
| a_out | output | DATA_W | Value to drive on the A-side pins |
| a_oe | output | 1 | A-side drive enable |
| b_in | input | DATA_W | Value sensed on the B-side data pins |
| b_out | output | DATA_W | Value to drive on the B-side data pins |
| b_oe | output | 1 | B-side data drive enable |
| par_in | input | 1 | Value sensed on the parity pin |
| par_out | output | 1 | Value to drive on the parity pin |
| par_oe | output | 1 | Parity pin drive enable |
| err_n | output | 1 | Registered error level, low on error |
| err_drv | output | 1 | Error pin pull-down enable |

## Verification
On every cycle, the assertions check the enable decode for all four enable pairs, the inverted data paths, and the odd weight of the generated parity word. They also check the flag loaded toward A and in diagnostic mode, the tie between err_drv and err_n, and the hold of the no-error state while clear is low. Some behaviour only the bench's scenarios can show. These are an asynchronous clear that lands in the middle of a cycle, a flag that holds while inputs toggle between edges, and single-bit errors injected into each of the nine checked positions.

// File: rtl/par_bridge_pkg.sv
package par_bridge_pkg;
   // Transfer mode decoded from the two active-low enables {en_a_n, en_b_n}
   typedef enum logic [1:0] {
      XM_DIAG = 2'b00,   // both enabled: toward B with inverted parity
      XM_A2B  = 2'b10,   // only B drivers enabled
      XM_B2A  = 2'b01,   // only A drivers enabled
      XM_ISOL = 2'b11    // neither enabled
   } xfer_mode_e;
endpackage

// File: rtl/par_xor_tree.sv
module par_xor_tree #(
   parameter int W      = 8,
   parameter bit SERIAL = 1'b0
) (
   input  logic [W-1:0] vec,
   output logic         odd
);
   if (W < 1) begin : g_bad_w
      $error("par_xor_tree: W must be at least 1");
   end

   if (SERIAL) begin : g_serial
      // Ripple form: one gate per bit, smallest area
      always_comb begin
         odd = 1'b0;
         for (int i = 0; i < W; i++) odd = odd ^ vec[i];
      end
   end else begin : g_reduce
      // Reduction form: synthesis balances it into a log-depth tree
      assign odd = ^vec;
   end
endmodule

// File: rtl/par_mode_dec.sv
module par_mode_dec
   import par_bridge_pkg::*;
(
   input  logic       en_a_n,
   input  logic       en_b_n,
   output xfer_mode_e mode,
   output logic       a_oe,
   output logic       b_oe
);
   always_comb begin
      mode = xfer_mode_e'({en_a_n, en_b_n});
      // Diagnostic mode keeps A released even though en_a_n is low
      a_oe = (mode == XM_B2A);
      b_oe = (mode == XM_A2B) || (mode == XM_DIAG);
   end
endmodule

// File: rtl/par_err_reg.sv
module par_err_reg (
   input  logic clk,
   input  logic clr_n,
   input  logic flag_d,
   output logic flag_q
);
   // Clear is asynchronous and wins over the clock
   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end
endmodule

// File: rtl/par_bridge.sv
module par_bridge
   import par_bridge_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit PAR_SERIAL = 1'b0
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              en_a_n,
   input  logic              en_b_n,
   input  logic [DATA_W-1:0] a_in,
   output logic [DATA_W-1:0] a_out,
   output logic              a_oe,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] b_out,
   output logic              b_oe,
   input  logic              par_in,
   output logic              par_out,
   output logic              par_oe,
   output logic              err_n,
   output logic              err_drv
);
   localparam int CHK_W = DATA_W + 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("par_bridge: DATA_W must be at least 2");
   end

   xfer_mode_e mode;
   logic       b_side_oe;
   logic       gen_odd;    // odd count of ones in the driven B data
   logic       chk_odd;    // odd count of ones in sensed B data plus parity
   logic       a_odd;      // odd count of ones in sensed A data
   logic       flag_d;
   logic       flag_q;

   par_mode_dec u_dec (
      .en_a_n (en_a_n),
      .en_b_n (en_b_n),
      .mode   (mode),
      .a_oe   (a_oe),
      .b_oe   (b_side_oe)
   );

   // Inverting data paths, both always computed; enables gate the pins
   assign b_out = ~a_in;
   assign a_out = ~b_in;
   assign b_oe   = b_side_oe;
   assign par_oe = b_side_oe;

   par_xor_tree #(.W(DATA_W), .SERIAL(PAR_SERIAL)) u_gen (
      .vec (b_out),
      .odd (gen_odd)
   );

   par_xor_tree #(.W(CHK_W), .SERIAL(PAR_SERIAL)) u_chk (
      .vec ({b_in, par_in}),
      .odd (chk_odd)
   );

   par_xor_tree #(.W(DATA_W), .SERIAL(PAR_SERIAL)) u_aiso (
      .vec (a_in),
      .odd (a_odd)
   );

   // Odd parity over the driven word; flipped in diagnostic mode
   assign par_out = (mode == XM_DIAG) ? gen_odd : ~gen_odd;

   always_comb begin
      unique case (mode)
         XM_A2B:  flag_d = 1'b0;
         XM_DIAG: flag_d = 1'b1;
         XM_B2A:  flag_d = ~chk_odd;
         XM_ISOL: flag_d = a_odd;
         default: flag_d = 1'b0;
      endcase
   end

   par_err_reg u_flag (
      .clk    (clk),
      .clr_n  (clr_n),
      .flag_d (flag_d),
      .flag_q (flag_q)
   );

   assign err_n   = ~flag_q;
   assign err_drv = flag_q;
endmodule

// File: rtl/par_bridge_chk.sv
module par_bridge_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              clr_n,
   input logic              en_a_n,
   input logic              en_b_n,
   input logic [DATA_W-1:0] a_in,
   input logic [DATA_W-1:0] a_out,
   input logic              a_oe,
   input logic [DATA_W-1:0] b_in,
   input logic [DATA_W-1:0] b_out,
   input logic              b_oe,
   input logic              par_in,
   input logic              par_out,
   input logic              par_oe,
   input logic              err_n,
   input logic              err_drv
);
   wire to_b  = en_a_n && !en_b_n;
   wire to_a  = !en_a_n && en_b_n;
   wire diag  = !en_a_n && !en_b_n;
   wire isol  = en_a_n && en_b_n;

   // R1
   a_r1_to_b_path: assert property (@(posedge clk) disable iff (!clr_n)
      to_b |-> (b_oe && par_oe && !a_oe && b_out == ~a_in));
   // R2
   a_r2_odd_word: assert property (@(posedge clk) disable iff (!clr_n)
      to_b |-> ($countones({b_out, par_out}) % 2 == 1));
   // R3
   a_r3_to_a_path: assert property (@(posedge clk) disable iff (!clr_n)
      to_a |-> (a_oe && !b_oe && !par_oe && a_out == ~b_in));
   // R4
   a_r4_check_flag: assert property (@(posedge clk) disable iff (!clr_n)
      to_a |=> (err_drv == ($countones({$past(b_in), $past(par_in)}) % 2 == 0)));
   // R5
   a_r5_forced_err: assert property (@(posedge clk) disable iff (!clr_n)
      diag |=> !err_n);
   // R5
   a_r5_diag_par: assert property (@(posedge clk) disable iff (!clr_n)
      diag |-> ($countones({b_out, par_out}) % 2 == 0) && b_oe && !a_oe);
   // R7
   a_r7_isolated: assert property (@(posedge clk) disable iff (!clr_n)
      isol |-> (!a_oe && !b_oe && !par_oe));
   // R10
   a_r10_open_drain: assert property (@(posedge clk) disable iff (!clr_n)
      err_drv == !err_n);
   // R9
   a_r9_clear_hold: assert property (@(posedge clk)
      !clr_n |=> err_n);
endmodule

bind par_bridge par_bridge_chk #(.DATA_W(DATA_W)) u_par_bridge_chk (
   .clk     (clk),
   .clr_n   (clr_n),
   .en_a_n  (en_a_n),
   .en_b_n  (en_b_n),
   .a_in    (a_in),
   .a_out   (a_out),
   .a_oe    (a_oe),
   .b_in    (b_in),
   .b_out   (b_out),
   .b_oe    (b_oe),
   .par_in  (par_in),
   .par_out (par_out),
   .par_oe  (par_oe),
   .err_n   (err_n),
   .err_drv (err_drv)
);

// File: tb/par_bridge_bench.sv
`timescale 1ns/1ps
module par_bridge_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         clr_n = 1'b0;
   logic         en_a_n = 1'b1;
   logic         en_b_n = 1'b1;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic         par_in = 1'b0;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe, par_out, par_oe, err_n, err_drv;

   int checks = 0;
   int errors = 0;
   bit last_err = 1'b0;

   typedef struct { bit err; string req; } exp_t;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   par_bridge #(.DATA_W(W)) u_par_bridge (
      .clk(clk), .clr_n(clr_n), .en_a_n(en_a_n), .en_b_n(en_b_n),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
      .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
      .err_n(err_n), .err_drv(err_drv)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_flag(input bit ea, input bit eb, input logic [W-1:0] a,
                                   input logic [W-1:0] b, input bit p);
      if (ea && !eb)      return 1'b0;                               // R6
      else if (!ea && !eb) return 1'b1;                              // R5
      else if (!ea && eb) return ($countones({b, p}) % 2 == 0);      // R4
      else                return ($countones(a) % 2 == 1);           // R7
   endfunction

   function automatic string flag_req(input bit ea, input bit eb);
      if (ea && !eb)       return "R6";
      else if (!ea && !eb) return "R5";
      else if (!ea && eb)  return "R4";
      else                 return "R7";
   endfunction

   // Driver: apply one input set at the falling edge, check combinational
   // outputs, queue the flag expected after the next rising edge.
   task automatic drive(input bit ea, input bit eb, input logic [W-1:0] a,
                        input logic [W-1:0] b, input bit p);
      bit   gp;
      exp_t it;
      @(negedge clk);
      en_a_n = ea; en_b_n = eb; a_in = a; b_in = b; par_in = p;
      #1;
      gp = ($countones(~a) % 2 == 0);
      if (ea && !eb) begin
         chk(b_oe && par_oe && !a_oe, "R1", {b_oe, par_oe, a_oe}, 3'b110);
         chk(b_out == ~a, "R1", b_out, ~a);
         chk(par_out == gp, "R2", par_out, gp);
      end else if (!ea && eb) begin
         chk(a_oe && !b_oe && !par_oe, "R3", {b_oe, par_oe, a_oe}, 3'b001);
         chk(a_out == ~b, "R3", a_out, ~b);
      end else if (!ea && !eb) begin
         chk(b_oe && par_oe && !a_oe, "R5", {b_oe, par_oe, a_oe}, 3'b110);
         chk(b_out == ~a, "R5", b_out, ~a);
         chk(par_out == !gp, "R5", par_out, !gp);
      end else begin
         chk(!a_oe && !b_oe && !par_oe, "R7", {b_oe, par_oe, a_oe}, 3'b000);
      end
      it.err = exp_flag(ea, eb, a, b, p);
      it.req = flag_req(ea, eb);
      sb_q.push_back(it);
      last_err = it.err;
   endtask

   // Monitor: after each rising edge, compare the registered flag
   always begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
         exp_t it;
         it = sb_q.pop_front();
         chk(err_n == !it.err, it.req, err_n, !it.err);
         chk(err_drv == it.err, "R10", err_drv, it.err);
      end
   end

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] d;
      bit good;
      // R11: clear state
      repeat (3) @(negedge clk);
      chk(err_n == 1'b1 && err_drv == 1'b0, "R11", {err_n, err_drv}, 2'b10);
      @(negedge clk);
      clr_n = 1'b1;

      // R1 R2 R6: toward B, corners and random data
      drive(1, 0, 8'h00, 8'h00, 0);
      drive(1, 0, 8'hFF, 8'h00, 0);
      drive(1, 0, 8'h01, 8'h00, 0);
      for (int i = 0; i < 12; i++) drive(1, 0, W'($urandom), W'($urandom), 1'($urandom));

      // R3 R4: toward A, good parity then each single-bit error
      for (int i = 0; i < 9; i++) begin
         d = W'($urandom);
         good = ($countones(d) % 2 == 0);     // makes the nine bits odd
         drive(0, 1, 8'h00, d, good);
         if (i < W) drive(0, 1, 8'h00, d ^ (W'(1) << i), good);
         else       drive(0, 1, 8'h00, d, !good);
      end

      // R5: diagnostic, flag forced after being clear
      drive(1, 0, 8'h5A, 8'h00, 0);
      drive(0, 0, 8'h5A, 8'h00, 0);
      drive(0, 0, 8'h00, 8'h00, 0);
      for (int i = 0; i < 4; i++) drive(0, 0, W'($urandom), W'($urandom), 1'($urandom));

      // R7: isolated, even and odd A
      drive(1, 1, 8'h03, 8'hAA, 1);
      drive(1, 1, 8'h07, 8'hAA, 1);
      for (int i = 0; i < 6; i++) drive(1, 1, W'($urandom), W'($urandom), 1'($urandom));

      // R8: flag holds while inputs change between edges
      drive(0, 0, 8'h11, 8'h00, 0);       // sets the flag
      @(negedge clk);
      en_a_n = 1; en_b_n = 0; a_in = 8'h22;
      #1 chk(err_n == !last_err, "R8", err_n, !last_err);
      #1 en_a_n = 0; en_b_n = 1; b_in = 8'h0F; par_in = 1;
      #1 chk(err_n == !last_err, "R8", err_n, !last_err);
      begin
         exp_t it;
         it.err = exp_flag(0, 1, 8'h22, 8'h0F, 1);
         it.req = "R4";
         sb_q.push_back(it);
         last_err = it.err;
      end

      // R9: asynchronous clear mid-cycle, held across an edge
      drive(0, 0, 8'h00, 8'h00, 0);
      @(posedge clk);
      #3 clr_n = 1'b0;
      #0.5 chk(err_n == 1'b1 && err_drv == 1'b0, "R9", {err_n, err_drv}, 2'b10);
      @(posedge clk);
      #1 chk(err_n == 1'b1, "R9", err_n, 1'b1);
      @(negedge clk);
      clr_n = 1'b1;
      drive(0, 1, 8'h00, 8'h00, 0);       // even word: error
      drive(1, 0, 8'h3C, 8'h00, 0);

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule